// File: doc/BRIEF.md
# Page-list transfer walker

This block turns the address description of a storage command into a stream of memory segments. A command gives two 64-bit pointers and a byte count. The block checks that the pointers describe a legal page-based scatter layout and then issues one (address, length) segment per touched page on a valid/ready stream. The page size is picked per command as a power of two.

The first pointer may start anywhere inside a page. What is left after that page is described by the second pointer in one of two ways. When the rest fits in one page, the second pointer is itself a page-aligned data address. Otherwise it points to a list of 8-byte entries, each naming one data page. The block fetches those entries one at a time over a simple memory read port. When the walk reaches the last entry of a full list page and more than one page of data is still left, that entry is the address of the next list page.

Any null or misaligned pointer ends the walk. The segments already issued stay issued, no further segment follows, and the block reports an invalid-field status with the do-not-retry bit set.

Top module: `page_list_walker`

## Requirements
- R1: A command whose first pointer is zero, or whose byte count is zero, ends with done=1, err=1 and status 16'h4002 (bit 14 is the do-not-retry flag, bits 7:0 hold invalid-field code 8'h02). It issues no segment and makes no read.
- R2: The first segment has address ptr_a and length min(xfer_len, page_size - (ptr_a mod page_size)).
- R3: If bytes remain after the first segment and ptr_b is zero, the walk ends in error right after the first segment.
- R4: If the remainder after the first segment is at most one page, the second and final segment is (ptr_b, remainder) and no read is made. If ptr_b is not page aligned in this case, the walk ends in error instead.
- R5: If the remainder is more than one page, entries are read from ptr_b, ptr_b+8, and so on. Each entry read is the whole 64-bit word on rd_rdata and names a data page. Each such segment has length min(remaining, page_size).
- R6: The entry at slot index page_size/8-1 of a list page is the address of the next list page when more than one page of data remains, and the walk then continues at slot 0 of that page. Otherwise that entry is data.
- R7: A zero entry, or an entry whose low page_bits bits are not all zero, ends the walk in error with status 16'h4002. No further read or segment follows it, and the segments already issued stand.
- R8: Exactly the final segment of a successful walk carries seg_last=1. In the cycle after its handshake, done=1 with err=0 and status 16'h0000.
- R9: While seg_valid is high and seg_ready is low, seg_addr, seg_len and seg_last hold.
- R10: A start pulse while busy is high has no effect on the walk in progress.
- R11: page_size is 2^cfg_page_bits, and cfg_page_bits is sampled only with an accepted start.
- R12: When the first segment covers the whole byte count, ptr_b is ignored, even when it is zero or misaligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk; taken only when busy is low |
| ptr_a | input | ADDR_W | First data pointer, any byte offset |
| ptr_b | input | ADDR_W | Second pointer: data page or list base |
| xfer_len | input | LEN_W | Total byte count |
| cfg_page_bits | input | PBW | log2 of the page size, PB_MIN..PB_MAX |
| busy | output | 1 | A walk is in progress |
| seg_valid | output | 1 | Segment available |
| seg_ready | input | 1 | Consumer takes the segment |
| seg_addr | output | ADDR_W | Segment start address |
| seg_len | output | LEN_W | Segment byte length |
| seg_last | output | 1 | Final segment of a successful walk |
| rd_req | output | 1 | List entry read request, held until rd_rvalid |
| rd_addr | output | ADDR_W | Byte address of the entry |
| rd_rvalid | input | 1 | Read data returned |
| rd_rdata | input | 64 | Entry value |
| done | output | 1 | One-cycle end-of-walk pulse |
| err | output | 1 | Walk failed; valid with done |
| status | output | 16 | Completion status; valid with done |

## Verification
The in-line properties check several rules on every cycle. Segments and read requests hold under backpressure. A first segment never crosses its page end. Every later segment is page aligned and at most one page long. A handshaken final segment is followed by a clean done. Which segments appear, in what order, and which entries are read can only be shown by the bench scenarios. These include the exact-fit slot that must not chain, a chained list, faults placed at a chosen point, and a start pulse that arrives mid-walk. Each scenario is compared against a bench model that walks the same sparse memory.

// File: rtl/pw_pkg.sv
`timescale 1ns/1ps
package pw_pkg;
   localparam int STAT_W    = 16;
   localparam int ENT_W     = 64;
   localparam int ENT_BYTES = ENT_W / 8;
   // bit 14: do not retry, low byte: invalid field
   localparam logic [STAT_W-1:0] STAT_OK  = 16'h0000;
   localparam logic [STAT_W-1:0] STAT_BAD = 16'h4002;

   typedef enum logic [2:0] {
      WS_IDLE,
      WS_HEAD,
      WS_OUT,
      WS_TAIL,
      WS_FETCH,
      WS_EVAL,
      WS_FIN
   } walk_st_t;
endpackage

// File: rtl/pw_page_mask.sv
`timescale 1ns/1ps
module pw_page_mask #(
   parameter int ADDR_W = 64,
   parameter int LEN_W  = 32,
   parameter int PBW    = 5
) (
   input  logic [PBW-1:0]    page_bits,
   output logic [ADDR_W-1:0] offs_mask,
   output logic [LEN_W-1:0]  page_size
);
   for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
      assign offs_mask[i] = (32'(i) < 32'(page_bits));
   end
   for (genvar j = 0; j < LEN_W; j++) begin : g_size
      assign page_size[j] = (32'(j) == 32'(page_bits));
   end
endmodule

// File: rtl/pw_ptr_check.sv
`timescale 1ns/1ps
module pw_ptr_check #(
   parameter int ADDR_W = 64
) (
   input  logic [ADDR_W-1:0] ptr,
   input  logic [ADDR_W-1:0] offs_mask,
   output logic              is_null,
   output logic              off_page
);
   assign is_null  = (ptr == '0);
   assign off_page = |(ptr & offs_mask);
endmodule

// File: rtl/pw_span_calc.sv
`timescale 1ns/1ps
module pw_span_calc #(
   parameter int ADDR_W = 64,
   parameter int LEN_W  = 32
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] offs_mask,
   input  logic [LEN_W-1:0]  page_size,
   input  logic [LEN_W-1:0]  remain,
   output logic [LEN_W-1:0]  head_len,
   output logic [LEN_W-1:0]  page_len,
   output logic              more_than_page
);
   logic [LEN_W-1:0] offs;
   logic [LEN_W-1:0] to_end;

   assign offs           = LEN_W'(addr & offs_mask);
   assign to_end         = page_size - offs;
   assign head_len       = (remain < to_end) ? remain : to_end;
   assign page_len       = (remain < page_size) ? remain : page_size;
   assign more_than_page = (remain > page_size);
endmodule

// File: rtl/page_list_walker.sv
`timescale 1ns/1ps
module page_list_walker
   import pw_pkg::*;
#(
   parameter  int ADDR_W = 64,
   parameter  int LEN_W  = 32,
   parameter  int PB_MIN = 12,
   parameter  int PB_MAX = 16,
   localparam int PBW    = $clog2(PB_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] ptr_a,
   input  logic [ADDR_W-1:0] ptr_b,
   input  logic [LEN_W-1:0]  xfer_len,
   input  logic [PBW-1:0]    cfg_page_bits,
   output logic              busy,
   output logic              seg_valid,
   input  logic              seg_ready,
   output logic [ADDR_W-1:0] seg_addr,
   output logic [LEN_W-1:0]  seg_len,
   output logic              seg_last,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_rvalid,
   input  logic [ENT_W-1:0]  rd_rdata,
   output logic              done,
   output logic              err,
   output logic [STAT_W-1:0] status
);
   initial begin : p_cfg
      assert (PB_MIN >= 3 && PB_MIN <= PB_MAX && PB_MAX < LEN_W && ADDR_W <= ENT_W && ADDR_W > PB_MAX)
         else $fatal(1, "page_list_walker: illegal parameter set");
   end

   walk_st_t          st;
   logic [ADDR_W-1:0] pa_q, pb_q, lst_q, ent_q, sa_q;
   logic [LEN_W-1:0]  rem_q, sl_q, slot_q;
   logic [PBW-1:0]    pbits_q;
   logic              slast_q, first_q, err_q;

   logic [ADDR_W-1:0] pmask;
   logic [LEN_W-1:0]  psize, last_slot;
   logic [LEN_W-1:0]  head_len, page_len;
   logic              more_pg;
   logic              b_null, b_off, e_null, e_off;

   pw_page_mask #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PBW(PBW)) u_mask (
      .page_bits (pbits_q),
      .offs_mask (pmask),
      .page_size (psize)
   );

   pw_span_calc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_span (
      .addr           (pa_q),
      .offs_mask      (pmask),
      .page_size      (psize),
      .remain         (rem_q),
      .head_len       (head_len),
      .page_len       (page_len),
      .more_than_page (more_pg)
   );

   pw_ptr_check #(.ADDR_W(ADDR_W)) u_chk_b (
      .ptr       (pb_q),
      .offs_mask (pmask),
      .is_null   (b_null),
      .off_page  (b_off)
   );

   pw_ptr_check #(.ADDR_W(ADDR_W)) u_chk_e (
      .ptr       (ent_q),
      .offs_mask (pmask),
      .is_null   (e_null),
      .off_page  (e_off)
   );

   assign last_slot = (psize >> 3) - LEN_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= WS_IDLE;
         pa_q    <= '0;
         pb_q    <= '0;
         lst_q   <= '0;
         ent_q   <= '0;
         sa_q    <= '0;
         rem_q   <= '0;
         sl_q    <= '0;
         slot_q  <= '0;
         pbits_q <= PBW'(PB_MIN);
         slast_q <= 1'b0;
         first_q <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         unique case (st)
            WS_IDLE: begin
               if (start) begin
                  pa_q    <= ptr_a;
                  pb_q    <= ptr_b;
                  rem_q   <= xfer_len;
                  pbits_q <= cfg_page_bits;
                  first_q <= 1'b1;
                  err_q   <= 1'b0;
                  st      <= WS_HEAD;
               end
            end
            WS_HEAD: begin
               if (pa_q == '0 || rem_q == '0) begin
                  err_q <= 1'b1;
                  st    <= WS_FIN;
               end else begin
                  sa_q    <= pa_q;
                  sl_q    <= head_len;
                  slast_q <= (head_len == rem_q);
                  st      <= WS_OUT;
               end
            end
            WS_OUT: begin
               if (seg_ready) begin
                  rem_q   <= rem_q - sl_q;
                  first_q <= 1'b0;
                  if (slast_q) begin
                     st <= WS_FIN;
                  end else if (first_q) begin
                     st <= WS_TAIL;
                  end else begin
                     lst_q  <= lst_q + ADDR_W'(ENT_BYTES);
                     slot_q <= slot_q + LEN_W'(1);
                     st     <= WS_FETCH;
                  end
               end
            end
            WS_TAIL: begin
               if (b_null) begin
                  err_q <= 1'b1;
                  st    <= WS_FIN;
               end else if (!more_pg) begin
                  if (b_off) begin
                     err_q <= 1'b1;
                     st    <= WS_FIN;
                  end else begin
                     sa_q    <= pb_q;
                     sl_q    <= rem_q;
                     slast_q <= 1'b1;
                     st      <= WS_OUT;
                  end
               end else begin
                  lst_q  <= pb_q;
                  slot_q <= '0;
                  st     <= WS_FETCH;
               end
            end
            WS_FETCH: begin
               if (rd_rvalid) begin
                  ent_q <= rd_rdata[ADDR_W-1:0];
                  st    <= WS_EVAL;
               end
            end
            WS_EVAL: begin
               if (e_null || e_off) begin
                  err_q <= 1'b1;
                  st    <= WS_FIN;
               end else if (slot_q == last_slot && more_pg) begin
                  lst_q  <= ent_q;
                  slot_q <= '0;
                  st     <= WS_FETCH;
               end else begin
                  sa_q    <= ent_q;
                  sl_q    <= page_len;
                  slast_q <= !more_pg;
                  st      <= WS_OUT;
               end
            end
            WS_FIN: st <= WS_IDLE;
            default: st <= WS_IDLE;
         endcase
      end
   end

   assign busy      = (st != WS_IDLE);
   assign seg_valid = (st == WS_OUT);
   assign seg_addr  = sa_q;
   assign seg_len   = sl_q;
   assign seg_last  = slast_q;
   assign rd_req    = (st == WS_FETCH);
   assign rd_addr   = lst_q;
   assign done      = (st == WS_FIN);
   assign err       = done & err_q;
   assign status    = err ? STAT_BAD : STAT_OK;

   // backpressure keeps the offered segment intact
   assert_seg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      seg_valid && !seg_ready |=> seg_valid && $stable(seg_addr) && $stable(seg_len) && $stable(seg_last));

   // a pending read keeps its address until answered
   assert_rd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req && !rd_rvalid |=> rd_req && $stable(rd_addr));

   // the head segment never runs past the end of its page
   assert_head_in_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
      seg_valid && first_q |->
         seg_len != '0 && ({1'b0, seg_len} + {1'b0, LEN_W'(seg_addr & pmask)}) <= {1'b0, psize});

   // later segments start on a page boundary
   assert_body_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
      seg_valid && !first_q |-> (seg_addr & pmask) == '0 && seg_addr != '0);

   // later segments span at most one page and are never empty
   assert_body_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
      seg_valid |-> seg_len != '0 && seg_len <= psize);

   // a taken final segment is followed by a clean completion
   assert_last_then_ok_R8: assert property (@(posedge clk) disable iff (!rst_n)
      seg_valid && seg_ready && seg_last |=> done && !err && status == STAT_OK);

   // accepted page size must lie in the supported range
   assert_cfg_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy |-> cfg_page_bits >= PBW'(PB_MIN) && cfg_page_bits <= PBW'(PB_MAX));
endmodule

// File: tb/test_page_list_walker.sv
`timescale 1ns/1ps
module test_page_list_walker;
   import pw_pkg::*;
   localparam int AW    = 64;
   localparam int LW    = 32;
   localparam int PBMIN = 5;
   localparam int PBMAX = 12;
   localparam int PBW   = $clog2(PBMAX + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] ptr_a = '0, ptr_b = '0;
   logic [LW-1:0] xfer_len = '0;
   logic [PBW-1:0] cfg_page_bits = PBW'(PBMIN);
   logic          busy, seg_valid, seg_last, rd_req, done, err;
   logic          seg_ready = 1'b0;
   logic [AW-1:0] seg_addr, rd_addr;
   logic [LW-1:0] seg_len;
   logic          rd_rvalid = 1'b0;
   logic [63:0]   rd_rdata = '0;
   logic [15:0]   status;

   always #2 clk = ~clk;   // 250 MHz

   page_list_walker #(.ADDR_W(AW), .LEN_W(LW), .PB_MIN(PBMIN), .PB_MAX(PBMAX)) i_page_list_walker (
      .clk(clk), .rst_n(rst_n), .start(start), .ptr_a(ptr_a), .ptr_b(ptr_b),
      .xfer_len(xfer_len), .cfg_page_bits(cfg_page_bits), .busy(busy),
      .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
      .seg_len(seg_len), .seg_last(seg_last), .rd_req(rd_req), .rd_addr(rd_addr),
      .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata), .done(done), .err(err), .status(status)
   );

   logic [63:0] mem [logic [63:0]];
   logic [63:0] exp_a[$];
   logic [31:0] exp_l[$];
   bit          exp_err;
   int          exp_reads;
   logic [63:0] got_a[$];
   logic [31:0] got_l[$];
   bit          got_last[$];
   int          got_reads;
   bit          got_err;
   logic [15:0] got_stat;
   int          total = 0;
   int          bad = 0;
   bit          finished = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [63:0] rd_mem(input logic [63:0] a);
      return mem.exists(a) ? mem[a] : 64'd0;
   endfunction

   // independent walk of the same memory, from the requirements
   function automatic void model(input logic [63:0] p1, input logic [63:0] p2,
                                 input logic [31:0] len, input int pb);
      logic [63:0] ps, la, e;
      logic [63:0] f, r, n;
      int slot;
      exp_a.delete(); exp_l.delete(); exp_err = 0; exp_reads = 0;
      ps = 64'd1 << pb;
      if (p1 == 0 || len == 0) begin exp_err = 1; return; end
      f = ps - (p1 & (ps - 1));
      if (f > 64'(len)) f = 64'(len);
      exp_a.push_back(p1); exp_l.push_back(32'(f));
      r = 64'(len) - f;
      if (r == 0) return;
      if (p2 == 0) begin exp_err = 1; return; end
      if (r <= ps) begin
         if ((p2 & (ps - 1)) != 0) exp_err = 1;
         else begin exp_a.push_back(p2); exp_l.push_back(32'(r)); end
         return;
      end
      la = p2; slot = 0;
      while (r > 0) begin
         e = rd_mem(la); exp_reads++;
         if (e == 0 || (e & (ps - 1)) != 0) begin exp_err = 1; return; end
         if (64'(slot) == ps / 8 - 1 && r > ps) begin
            la = e; slot = 0;
         end else begin
            n = (r < ps) ? r : ps;
            exp_a.push_back(e); exp_l.push_back(32'(n));
            r = r - n; la = la + 8; slot++;
         end
      end
   endfunction

   task automatic run(input string req, input logic [63:0] p1, input logic [63:0] p2,
                      input logic [31:0] len, input int pb, input bit dup);
      int cyc, lat, nlast, mis;
      bit fin;
      model(p1, p2, len, pb);
      got_a.delete(); got_l.delete(); got_last.delete(); got_reads = 0;
      got_err = 0; got_stat = '0;
      @(negedge clk);
      start = 1; ptr_a = p1; ptr_b = p2; xfer_len = len; cfg_page_bits = PBW'(pb);
      @(negedge clk);
      start = 0;
      cyc = 0; fin = 0; lat = $urandom_range(0, 2);
      while (!fin && cyc < 3000) begin
         if (dup && cyc == 2) begin
            start = 1; ptr_a = '0; ptr_b = 64'h3; xfer_len = 5; cfg_page_bits = PBW'(PBMAX);
         end else if (dup && cyc == 3) begin
            start = 0;
         end
         if (done) begin
            got_err = err; got_stat = status; fin = 1;
         end else begin
            if (seg_valid) begin
               seg_ready = ($urandom_range(0, 3) != 0);
               if (seg_ready) begin
                  got_a.push_back(seg_addr); got_l.push_back(seg_len); got_last.push_back(seg_last);
               end
            end else begin
               seg_ready = $urandom_range(0, 1);
            end
            if (rd_req) begin
               if (lat == 0) begin
                  rd_rvalid = 1; rd_rdata = rd_mem(rd_addr); got_reads++;
                  lat = $urandom_range(0, 2);
               end else begin
                  lat--; rd_rvalid = 0;
               end
            end else begin
               rd_rvalid = 0;
            end
            @(negedge clk);
            cyc++;
         end
      end
      start = 0; seg_ready = 0; rd_rvalid = 0;
      check(fin, req, "walk completes", 64'(cyc), 64'd0);
      mis = -1;
      for (int i = 0; i < got_a.size() && i < exp_a.size(); i++)
         if (mis < 0 && (got_a[i] != exp_a[i] || got_l[i] != exp_l[i])) mis = i;
      if (mis >= 0)
         check(0, req, $sformatf("segment %0d addr (len act %0d exp %0d)", mis, got_l[mis], exp_l[mis]),
               got_a[mis], exp_a[mis]);
      else
         check(got_a.size() == exp_a.size(), req, "segment count", 64'(got_a.size()), 64'(exp_a.size()));
      check(got_err == exp_err, req, "err", 64'(got_err), 64'(exp_err));
      check(got_stat == (exp_err ? 16'h4002 : 16'h0000), req, "status",
            64'(got_stat), exp_err ? 64'h4002 : 64'h0);
      check(got_reads == exp_reads, req, "entry reads", 64'(got_reads), 64'(exp_reads));
      nlast = 0;
      foreach (got_last[i]) if (got_last[i]) nlast++;
      if (exp_err)
         check(nlast == 0, "R8", "last flag on failed walk", 64'(nlast), 64'd0);
      else
         check(nlast == 1 && got_last.size() > 0 && got_last[got_last.size()-1], "R8",
               "single last flag on final segment", 64'(nlast), 64'd1);
   endtask

   task automatic rand_run();
      int pb, slot, npg, nlp, fault, k;
      logic [63:0] ps, p1, p2, la, nl;
      logic [31:0] len, f, r;
      logic [63:0] keys[$];
      pb = $urandom_range(PBMIN, 7);
      ps = 64'd1 << pb;
      mem.delete();
      npg = 0; nlp = 0;
      len = $urandom_range(1, 32'(12 * ps));
      p1 = (64'($urandom_range(1, 4095)) << pb) | 64'($urandom_range(0, 32'(ps - 1)));
      f = 32'(ps - (p1 & (ps - 1)));
      if (f > len) f = len;
      r = len - f;
      if (r == 0) begin
         p2 = {$urandom, $urandom};
      end else if (64'(r) <= ps) begin
         p2 = 64'h1_0000_0000 + (64'(npg) << pb); npg++;
      end else begin
         la = 64'h8_0000_0000; nlp = 1; p2 = la; slot = 0;
         while (r > 0) begin
            if (64'(slot) == ps / 8 - 1 && 64'(r) > ps) begin
               nl = 64'h8_0000_0000 + (64'(nlp) << pb); nlp++;
               mem[la] = nl; keys.push_back(la); la = nl; slot = 0;
            end else begin
               mem[la] = 64'h1_0000_0000 + (64'(npg) << pb); npg++;
               keys.push_back(la);
               r = r - ((64'(r) > ps) ? 32'(ps) : r);
               la = la + 8; slot++;
            end
         end
      end
      fault = $urandom_range(0, 11);
      case (fault)
         0: p1 = '0;
         1: p2 = '0;
         2: if (keys.size() > 0) begin k = $urandom_range(0, keys.size() - 1); mem[keys[k]] = '0; end
         3: if (keys.size() > 0) begin
               k = $urandom_range(0, keys.size() - 1);
               mem[keys[k]] = mem[keys[k]] | (64'd1 << $urandom_range(0, pb - 1));
            end
         4: p2 = p2 | (64'd1 << $urandom_range(0, pb - 1));
         5: len = '0;
         default: ;
      endcase
      run("R2/R5/R6/R7/R9 random", p1, p2, len, pb, 0);
   endtask

   initial begin
      #(4 * 190000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7321));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check(!busy, "R8", "reset busy", 64'(busy), 64'd0);
      check(!seg_valid && !rd_req, "R8", "reset seg/rd idle", {62'd0, seg_valid, rd_req}, 64'd0);
      check(!done && !err, "R8", "reset done/err", {62'd0, done, err}, 64'd0);
      check(status == 16'h0, "R1", "reset status", 64'(status), 64'd0);

      // R1: null first pointer, zero length
      mem.delete();
      run("R1 null ptr_a", 64'h0, 64'h2000, 100, 5, 0);
      run("R1 zero length", 64'h1000, 64'h2000, 0, 5, 0);
      // R2/R12: fits in head page, ptr_b ignored
      run("R12 ptr_b zero ignored", 64'h1010, 64'h0, 8, 5, 0);
      run("R2 exact to page end", 64'h1010, 64'h7, 16, 5, 0);
      // R3: remainder with null ptr_b
      run("R3 ptr_b null", 64'h1010, 64'h0, 17, 5, 0);
      // R4: direct second page, aligned and misaligned
      run("R4 direct second page", 64'h1000, 64'h2000, 64, 5, 0);
      run("R4 misaligned ptr_b", 64'h1008, 64'h2004, 40, 5, 0);
      // R6: exact fit in last slot is data
      mem.delete();
      mem[64'h4000] = 64'h10000; mem[64'h4008] = 64'h10020;
      mem[64'h4010] = 64'h10040; mem[64'h4018] = 64'h10060;
      run("R6 last slot is data", 64'h1000, 64'h4000, 160, 5, 0);
      // R6: one byte more chains to next list page
      mem[64'h4018] = 64'h5000; mem[64'h5000] = 64'h10060; mem[64'h5008] = 64'h10080;
      run("R6 chained list", 64'h1000, 64'h4000, 161, 5, 0);
      // R10/R11: start while busy, page size changed mid-walk
      run("R10 start while busy", 64'h1000, 64'h4000, 161, 5, 1);
      // R7: null data entry in second list page
      mem[64'h5000] = 64'h0;
      run("R7 null entry", 64'h1000, 64'h4000, 161, 5, 0);
      mem[64'h5000] = 64'h10060;
      mem[64'h4008] = 64'h10021;
      run("R7 misaligned entry", 64'h1000, 64'h4000, 161, 5, 0);
      mem[64'h4008] = 64'h10020;
      mem[64'h4018] = 64'h5008;
      run("R7 misaligned chain pointer", 64'h1000, 64'h4000, 161, 5, 0);
      // R11: larger page size
      mem.delete();
      mem[64'h20000] = 64'h30000; mem[64'h20008] = 64'h30100;
      run("R11 page_bits 8", 64'h1080, 64'h20000, 600, 8, 0);
      run("R5 list walk", 64'h1080, 64'h20000, 500, 8, 0);

      for (int t = 0; t < 120; t++) rand_run();

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule